// File: doc/BRIEF.md
# Bit-Spread PWM Converter

This block turns digital values into pulse trains that an external RC filter smooths into DC levels. It has a bank of 6-bit channels and one 14-bit channel, all driven by one shared timebase. A channel does not produce a single solid pulse per frame. Its high time is cut into weighted slices that are spread evenly across the frame, so the ripple after the filter sits at a much higher frequency than the frame rate.

The base time unit τ lasts two clock cycles. A 6-bit frame has 64 segments of `SEG_TAU` τ each. Data bit k of a 6-bit value owns 2^k of those segments, and the owning segment is set by the position of the lowest set bit of the segment index.

The 14-bit channel runs 64 short periods of 2^`COARSE_W` τ each. In every short period it is high for the coarse value in τ. Its 6 fine bits use the same spreading pattern to pick which short periods get one extra τ.

Software writes through a single write strobe. New values are staged and only reach a channel at its next frame boundary. A per-pin select bit chooses between the PWM waveform and a plain port input.

Top module: `bitspread_pwm`

## Requirements
- R1: After reset every select bit is 0. Each pin then follows its port input: `pwm6_pin[i]` follows `port6_in[i]` and `pwm14_pin` follows `port14_in`. The same holds whenever a select bit is cleared.
- R2: A pin whose select bit is 1 stays low until its channel has had a value transferred into its active latch.
- R3: A 6-bit channel holding value v is high for v × `SEG_TAU` τ per frame (v × 2 × `SEG_TAU` clocks). Segment 0 is always low, so 63/64 is the largest duty.
- R4: Segment index s (0..63) is high when s ≠ 0 and bit (5 − the position of the lowest set bit of s) of the value is 1. So bit 5 covers the odd segments, bit 4 covers s ≡ 2 mod 4, and so on down to bit 0, which covers segment 32. The high slices of different bits are therefore scattered across the frame and not merged into one pulse.
- R5: The 14-bit channel is high for D_H τ at the start of each of its 64 short periods, where D_H is the coarse value.
- R6: The 6 fine bits L add one τ to short period p whenever segment p would be high for a 6-bit value L under R4. The total high time per frame is therefore (64 × D_H + L) τ.
- R7: A write to the coarse register alone does not change the 14-bit output. The coarse and fine parts move together into the active latch only after a write to the fine register.
- R8: A staged value reaches the active latch only at the frame boundary of its channel, so a frame never mixes an old value with a new one.
- R9: Register map on `wr_addr`. Addresses 0..`NCH6`−1 take a 6-bit channel value in `wr_data[5:0]`. Address `NCH6` takes the coarse value in `wr_data[COARSE_W-1:0]`. Address `NCH6`+1 takes the fine value in `wr_data[5:0]` and triggers the transfer. Address `NCH6`+2 takes the 6-bit select mask in `wr_data[NCH6-1:0]`. Address `NCH6`+3 takes the 14-bit select in `wr_data[0]`.
- R10: τ alternates strictly: the internal tick is active on every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| port6_in | input | NCH6 | Port data used on 6-bit pins whose select is 0 |
| port14_in | input | 1 | Port data used on the 14-bit pin when its select is 0 |
| pwm6_pin | output | NCH6 | 6-bit channel pins |
| pwm14_pin | output | 1 | 14-bit channel pin |

## Verification
Each 6-bit channel is measured over a whole frame for both its high-clock count and its count of rising edges.

The test values are:
- 0x01, 0x10, 0x20 and 0x15, single bits and a mix that a single-pulse design would merge. Their edge counts (1, 16, 32, 21) show that the slices are spread.
- 0x3F, which shows the empty segment 0.

The 14-bit channel is tried with:
- a pure coarse value, which gives 64 pulses;
- a pure fine LSB, which gives one τ in one frame;
- coarse with fine bit 5, which stretches alternate periods;
- full scale, which merges into one long pulse.

A write placed mid-frame shows the frame-boundary transfer, and a lone coarse write shows that the fine write is the transfer trigger.

// File: rtl/bitspread_pwm_pkg.sv
package bitspread_pwm_pkg;

    localparam int VAL6_W = 6;
    localparam int NSEG   = 1 << VAL6_W;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic                 wr;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
    } reg_wr_t;

    typedef struct packed {
        logic              valid;
        logic [VAL6_W-1:0] value;
    } slot6_t;

    // Slice owner: the lowest set bit of the segment index picks the data bit.
    function automatic logic slice_on(input logic [VAL6_W-1:0] value,
                                      input logic [VAL6_W-1:0] seg);
        logic hit;
        logic found;
        hit   = 1'b0;
        found = 1'b0;
        for (int k = 0; k < VAL6_W; k++) begin
            if (!found && seg[k]) begin
                found = 1'b1;
                hit   = value[VAL6_W-1-k];
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import bitspread_pwm_pkg::*;
#(
    parameter int SEG_TAU  = 4,
    parameter int COARSE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    output logic                tau_en,
    output logic [VAL6_W-1:0]   seg6,
    output logic                frame6_wrap,
    output logic [COARSE_W-1:0] q14,
    output logic [VAL6_W-1:0]   per14,
    output logic                frame14_wrap
);

    localparam int SUB_W = (SEG_TAU > 1) ? $clog2(SEG_TAU) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SEG_TAU - 1);

    logic [SUB_W-1:0] sub;
    logic             seg_step;

    assign seg_step     = tau_en && (sub == SUB_LAST);
    assign frame6_wrap  = seg_step && (&seg6);
    assign frame14_wrap = tau_en && (&q14) && (&per14);

    always_ff @(posedge clk) begin
        if (rst) tau_en <= 1'b0;
        else     tau_en <= ~tau_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub  <= '0;
            seg6 <= '0;
        end else if (tau_en) begin
            if (sub == SUB_LAST) begin
                sub  <= '0;
                seg6 <= seg6 + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q14   <= '0;
            per14 <= '0;
        end else if (tau_en) begin
            q14 <= q14 + 1'b1;
            if (&q14) per14 <= per14 + 1'b1;
        end
    end

endmodule

// File: rtl/pwm6_channel.sv
module pwm6_channel
    import bitspread_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [VAL6_W-1:0] wr_val,
    input  logic              frame_wrap,
    input  logic [VAL6_W-1:0] seg,
    output slot6_t            active,
    output logic              pwm
);

    logic [VAL6_W-1:0] staged;
    logic              staged_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged      <= '0;
            staged_full <= 1'b0;
            active      <= '0;
        end else begin
            if (frame_wrap && staged_full) begin
                active.value <= staged;
                active.valid <= 1'b1;
                staged_full  <= 1'b0;
            end
            if (wr_stb) begin
                staged      <= wr_val;
                staged_full <= 1'b1;
            end
        end
    end

    assign pwm = active.valid && slice_on(active.value, seg);

endmodule

// File: rtl/pwm14_channel.sv
module pwm14_channel
    import bitspread_pwm_pkg::*;
#(
    parameter int COARSE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_coarse,
    input  logic                wr_fine,
    input  logic [COARSE_W-1:0] wr_coarse_val,
    input  logic [VAL6_W-1:0]   wr_fine_val,
    input  logic                frame_wrap,
    input  logic [COARSE_W-1:0] q,
    input  logic [VAL6_W-1:0]   per,
    output logic                valid,
    output logic                pwm
);

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [VAL6_W-1:0]   fine;
    } dac_word_t;

    logic [COARSE_W-1:0] coarse_reg;
    dac_word_t           staged;
    logic                staged_full;
    dac_word_t           act;
    logic [COARSE_W:0]   thresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_reg  <= '0;
            staged      <= '0;
            staged_full <= 1'b0;
            act         <= '0;
            valid       <= 1'b0;
        end else begin
            if (wr_coarse) coarse_reg <= wr_coarse_val;
            if (frame_wrap && staged_full) begin
                act         <= staged;
                valid       <= 1'b1;
                staged_full <= 1'b0;
            end
            if (wr_fine) begin
                staged.coarse <= coarse_reg;
                staged.fine   <= wr_fine_val;
                staged_full   <= 1'b1;
            end
        end
    end

    assign thresh = {1'b0, act.coarse} + {{COARSE_W{1'b0}}, slice_on(act.fine, per)};
    assign pwm    = valid && ({1'b0, q} < thresh);

endmodule

// File: rtl/bitspread_pwm.sv
module bitspread_pwm
    import bitspread_pwm_pkg::*;
#(
    parameter int NCH6     = 8,
    parameter int SEG_TAU  = 4,
    parameter int COARSE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NCH6-1:0]   port6_in,
    input  logic              port14_in,
    output logic [NCH6-1:0]   pwm6_pin,
    output logic              pwm14_pin
);

    localparam logic [ADDR_W-1:0] A_COARSE = ADDR_W'(NCH6);
    localparam logic [ADDR_W-1:0] A_FINE   = ADDR_W'(NCH6 + 1);
    localparam logic [ADDR_W-1:0] A_SEL6   = ADDR_W'(NCH6 + 2);
    localparam logic [ADDR_W-1:0] A_SEL14  = ADDR_W'(NCH6 + 3);

    reg_wr_t                   wreq;
    logic                      tau_en;
    logic [VAL6_W-1:0]         seg6;
    logic                      frame6_wrap;
    logic [COARSE_W-1:0]       q14;
    logic [VAL6_W-1:0]         per14;
    logic                      frame14_wrap;
    logic [NCH6-1:0]           raw6;
    logic [NCH6*VAL6_W-1:0]    lat6_flat;
    logic                      raw14;
    logic                      valid14;
    logic [NCH6-1:0]           sel6;
    logic                      sel14;

    assign wreq = '{wr: wr_en, addr: wr_addr, data: wr_data};

    pwm_timebase #(.SEG_TAU(SEG_TAU), .COARSE_W(COARSE_W)) u_tb (
        .clk(clk), .rst(rst), .tau_en(tau_en), .seg6(seg6),
        .frame6_wrap(frame6_wrap), .q14(q14), .per14(per14),
        .frame14_wrap(frame14_wrap)
    );

    for (genvar i = 0; i < NCH6; i++) begin : g_ch6
        slot6_t slot;
        pwm6_channel u_ch (
            .clk(clk), .rst(rst),
            .wr_stb(wreq.wr && (wreq.addr == ADDR_W'(i))),
            .wr_val(wreq.data[VAL6_W-1:0]),
            .frame_wrap(frame6_wrap), .seg(seg6),
            .active(slot), .pwm(raw6[i])
        );
        assign lat6_flat[i*VAL6_W +: VAL6_W] = slot.value;
        assign pwm6_pin[i] = sel6[i] ? raw6[i] : port6_in[i];
    end

    pwm14_channel #(.COARSE_W(COARSE_W)) u_ch14 (
        .clk(clk), .rst(rst),
        .wr_coarse(wreq.wr && (wreq.addr == A_COARSE)),
        .wr_fine(wreq.wr && (wreq.addr == A_FINE)),
        .wr_coarse_val(wreq.data[COARSE_W-1:0]),
        .wr_fine_val(wreq.data[VAL6_W-1:0]),
        .frame_wrap(frame14_wrap), .q(q14), .per(per14),
        .valid(valid14), .pwm(raw14)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel6  <= '0;
            sel14 <= 1'b0;
        end else if (wreq.wr) begin
            if (wreq.addr == A_SEL6)  sel6  <= wreq.data[NCH6-1:0];
            if (wreq.addr == A_SEL14) sel14 <= wreq.data[0];
        end
    end

    assign pwm14_pin = sel14 ? raw14 : port14_in;

endmodule

// File: rtl/bitspread_pwm_chk.sv
module bitspread_pwm_chk #(
    parameter int NCH6 = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                tau_en,
    input logic [5:0]          seg6,
    input logic                frame6_wrap,
    input logic [NCH6*6-1:0]   lat6_flat,
    input logic [NCH6-1:0]     raw6,
    input logic                valid14,
    input logic                raw14,
    input logic [NCH6-1:0]     pwm6_pin,
    input logic [NCH6-1:0]     port6_in,
    input logic [NCH6-1:0]     sel6
);

    p_port_fallback_r1: assert property (@(posedge clk) disable iff (rst)
        ((pwm6_pin ^ port6_in) & ~sel6) == '0);

    p_unlatched_low_r2: assert property (@(posedge clk) disable iff (rst)
        !valid14 |-> !raw14);

    p_seg0_low_r3: assert property (@(posedge clk) disable iff (rst)
        (seg6 == 6'd0) |-> (raw6 == '0));

    p_latch_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        (lat6_flat != $past(lat6_flat)) |-> $past(frame6_wrap));

    p_tau_alternate_r10: assert property (@(posedge clk) disable iff (rst)
        tau_en |=> !tau_en);

    p_tau_resume_r10: assert property (@(posedge clk) disable iff (rst)
        !tau_en |=> tau_en);

endmodule

bind bitspread_pwm bitspread_pwm_chk #(.NCH6(NCH6)) u_chk (
    .clk(clk), .rst(rst), .tau_en(tau_en), .seg6(seg6),
    .frame6_wrap(frame6_wrap), .lat6_flat(lat6_flat), .raw6(raw6),
    .valid14(valid14), .raw14(raw14), .pwm6_pin(pwm6_pin),
    .port6_in(port6_in), .sel6(sel6)
);

// File: tb/bitspread_pwm_test.sv
module bitspread_pwm_test;

    localparam int NCH6     = 8;
    localparam int SEG_TAU  = 4;
    localparam int COARSE_W = 5;
    localparam int F6       = 64 * SEG_TAU * 2;
    localparam int F14      = 64 * (1 << COARSE_W) * 2;

    localparam int T6_N = 6;
    localparam int T6_VAL  [T6_N] = '{0, 1, 32, 16, 63, 21};
    localparam int T6_EDGE [T6_N] = '{0, 1, 32, 16, 1, 21};

    localparam int T14_N = 4;
    localparam int T14_HI   [T14_N] = '{10, 0, 3, 31};
    localparam int T14_LO   [T14_N] = '{0, 1, 32, 63};
    localparam int T14_HIGH [T14_N] = '{1280, 2, 448, 4094};
    localparam int T14_EDGE [T14_N] = '{64, 1, 64, 1};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [NCH6-1:0] port6_in = 8'hA5;
    logic            port14_in = 1'b1;
    logic [NCH6-1:0] pwm6_pin;
    logic            pwm14_pin;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bitspread_pwm #(.NCH6(NCH6), .SEG_TAU(SEG_TAU), .COARSE_W(COARSE_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port6_in(port6_in), .port14_in(port14_in),
        .pwm6_pin(pwm6_pin), .pwm14_pin(pwm14_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a[3:0];
        wr_data = d[7:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic pin_of(input int which);
        return (which < NCH6) ? pwm6_pin[which] : pwm14_pin;
    endfunction

    task automatic measure(input int which, input int n, output int hi, output int rises);
        logic prev;
        logic cur;
        hi    = 0;
        rises = 0;
        @(negedge clk);
        prev = pin_of(which);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur = pin_of(which);
            if (cur) hi++;
            if (cur && !prev) rises++;
            prev = cur;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        int ed;
        logic prev;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state, pins follow port data
        @(negedge clk);
        chk("R1 pwm6_pin after reset", int'(pwm6_pin), 'hA5);
        chk("R1 pwm14_pin after reset", int'(pwm14_pin), 1);

        // R9: enable all selects; R2: nothing latched yet
        wr(NCH6 + 2, 'hFF);
        wr(NCH6 + 3, 1);
        measure(0, F6, hi, ed);
        chk("R2 6-bit pin low before latch", hi, 0);
        measure(NCH6, F14, hi, ed);
        chk("R2 14-bit pin low before latch", hi, 0);

        // R3 R4: table of 6-bit values, one per channel
        for (int r = 0; r < T6_N; r++) begin
            wr(r, T6_VAL[r]);
            repeat (2 * F6) @(negedge clk);
            measure(r, F6, hi, ed);
            chk($sformatf("R3 high clocks ch%0d val%0d", r, T6_VAL[r]), hi, T6_VAL[r] * SEG_TAU * 2);
            chk($sformatf("R4 pulses ch%0d val%0d", r, T6_VAL[r]), ed, T6_EDGE[r]);
        end

        // R8: write mid-frame, no change until the frame boundary
        wr(7, 1);
        repeat (2 * F6) @(negedge clk);
        prev = pwm6_pin[7];
        forever begin
            @(negedge clk);
            if (pwm6_pin[7] && !prev) break;
            prev = pwm6_pin[7];
        end
        wr(6, 63);
        measure(6, 200, hi, ed);
        chk("R8 no change before frame boundary", hi, 0);
        repeat (600) @(negedge clk);
        measure(6, F6, hi, ed);
        chk("R3 full scale after boundary", hi, 63 * SEG_TAU * 2);

        // R5 R6: 14-bit table
        for (int r = 0; r < T14_N; r++) begin
            wr(NCH6, T14_HI[r]);
            wr(NCH6 + 1, T14_LO[r]);
            repeat (2 * F14) @(negedge clk);
            measure(NCH6, F14, hi, ed);
            chk($sformatf("R6 high clocks hi%0d lo%0d", T14_HI[r], T14_LO[r]), hi, T14_HIGH[r]);
            chk($sformatf("R5 pulses hi%0d lo%0d", T14_HI[r], T14_LO[r]), ed, T14_EDGE[r]);
        end

        // R7: coarse write alone has no effect
        wr(NCH6, 20);
        repeat (2 * F14) @(negedge clk);
        measure(NCH6, F14, hi, ed);
        chk("R7 coarse-only write ignored", hi, 4094);

        // R1: clearing select returns pins to port data
        wr(NCH6 + 2, 'hFD);
        wr(NCH6 + 3, 0);
        port6_in  = 8'h02;
        port14_in = 1'b0;
        @(negedge clk);
        chk("R1 ch1 follows port high", int'(pwm6_pin[1]), 1);
        chk("R1 14-bit follows port", int'(pwm14_pin), 0);
        port6_in = 8'h00;
        @(negedge clk);
        chk("R1 ch1 follows port low", int'(pwm6_pin[1]), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule